// File: doc/BRIEF.md
# Periodic Interrupt Timer with Clock-Domain Crossing

This block raises an interrupt at a regular, software-chosen interval. The timing chain, a power-of-sixteen prescaler followed by an 8-bit modulus down counter, runs on a free-running reference clock. The software-visible registers run on a bus clock that has no fixed phase or frequency relation to the reference clock. Software picks a prescale rate and a modulus. The counter then produces one timeout every `(modulus + 1) * divider` reference cycles. Each timeout sets a sticky flag, and a new period begins on the next reference cycle.

Rate and modulus updates travel to the reference domain through a toggle handshake. A busy bit stays high until the reference side confirms that it has taken the new values. Timeout events travel back through a second toggle handshake, so events that occur while one is still crossing are merged and none is silently dropped. Three control bits decide whether the count holds in the system wait, stop and debug states. The three mode inputs are synchronized into the reference domain.

Top module: `periodic_irq_timer`

## Requirements
- R1: The rate field (address 1, bits [1:0]) selects the prescale divider: 01 divides by 1, 10 by 16 and 11 by 256. The modulus register (address 2, bits [7:0]) makes one timeout period last (modulus + 1) × divider reference-clock cycles.
- R2: With the rate field at 00 the counter does not advance and no timeout occurs.
- R3: Every timeout sets the flag (address 3, bit 0), and the next period starts without a gap. Consecutive timeouts are therefore exactly one period apart.
- R4: `irq` is high exactly when the flag is set and the enable bit (address 0, bit 0) is set. Clearing the enable masks the output.
- R5: Writing 1 to address 3 bit 0 clears the flag. Writing 0 there leaves the flag unchanged. A timeout arriving in the same bus cycle as a clear leaves the flag set.
- R6: While `wait_mode` is high, the count holds if the wait-hold bit (address 0, bit 1) is 1 and keeps running if it is 0.
- R7: While `stop_mode` is high, the count keeps running if the stop-run bit (address 0, bit 2) is 1 and holds if it is 0.
- R8: While `dbg_active` is high, the count holds if the debug-hold bit (address 0, bit 3) is 1. If that bit is 0, `dbg_active` has no effect.
- R9: An accepted write to the rate or modulus register sets the busy bit (address 3, bit 1) until the reference domain has taken the value. While busy is high, further rate or modulus writes are ignored and the registers keep their earlier contents.
- R10: When a new rate or modulus takes effect, the prescaler and the down counter restart from their reload values. The first timeout therefore comes one full new period after the update.
- R11: After reset every register reads 0, busy is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register-bank clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset, bus domain |
| ref_clk | input | 1 | Free-running counter clock, asynchronous to bus_clk |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| reg_addr | input | 2 | Register select: 0 control, 1 rate, 2 modulus, 3 status |
| reg_wr | input | 1 | Write strobe, sampled on bus_clk |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register (combinational) |
| wait_mode | input | 1 | System wait state, asynchronous |
| stop_mode | input | 1 | System stop state, asynchronous |
| dbg_active | input | 1 | Debugger halt state, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
A prescaler or down counter that restarts in the wrong place shows up as a wrong spacing between successive `irq` assertions. That spacing is measured in reference cycles within one period of the fault. A lost configuration handshake shows as busy stuck high or as a readback that a later write wrongly changed, and either is visible within a few bus cycles. A wrong hold qualification leaves the flag quiet while it should toggle, or toggling while it should hold. That difference is visible after a handful of periods.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
package pit_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_RATE = 2'd1,
    ADDR_MOD  = 2'd2,
    ADDR_STAT = 2'd3
  } pit_addr_e;

  localparam int RATE_W     = 2;
  localparam int PRESC_STEP = 4;
  localparam int DIV_W      = PRESC_STEP * ((2 ** RATE_W) - 2) + 1;
  localparam int PRESC_W    = DIV_W - 1;

  typedef struct packed {
    logic wait_hold;
    logic stop_run;
    logic dbg_hold;
  } pit_lp_t;

  // Divider for a rate code: 0 means stopped, otherwise 16**(code-1).
  function automatic logic [DIV_W-1:0] prescale_div(input logic [RATE_W-1:0] rate);
    if (rate == '0) return '0;
    return DIV_W'(1) << (PRESC_STEP * (int'(rate) - 1));
  endfunction

  // Hold condition from the synchronized mode inputs and control bits.
  function automatic logic lp_hold(input pit_lp_t c, input logic w, input logic s, input logic d);
    return (w & c.wait_hold) | (s & ~c.stop_run) | (d & c.dbg_hold);
  endfunction

  // Sticky flag: a set event dominates a simultaneous clear.
  function automatic logic flag_next(input logic flag, input logic set_ev, input logic clr_ev);
    return set_ev | (flag & ~clr_ev);
  endfunction

endpackage

// File: rtl/pit_sync.sv
`timescale 1ns/1ps
module pit_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/pit_bus_regs.sv
`timescale 1ns/1ps
module pit_bus_regs
  import pit_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MOD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic [RATE_W-1:0] rate_q,
  output logic [MOD_W-1:0]  mod_q,
  output pit_lp_t           lp_q,
  output logic              cfg_req_tog,
  input  logic              cfg_ack_tog,
  input  logic              evt_req_tog,
  output logic              evt_ack_tog
);

  logic irq_en_q;
  logic flag_q;
  logic evt_seen_q;
  logic cfg_ack_s;
  logic evt_req_s;

  // Named internal events
  logic busy;
  logic wr_ctrl, wr_rate, wr_mod, wr_stat;
  logic cfg_accept;
  logic set_evt;
  logic clr_evt;

  pit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cfg_ack_tog),
    .q    (cfg_ack_s)
  );

  pit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_evt_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (evt_req_tog),
    .q    (evt_req_s)
  );

  assign busy       = cfg_req_tog ^ cfg_ack_s;
  assign wr_ctrl    = wr_en && (addr == ADDR_CTRL);
  assign wr_rate    = wr_en && (addr == ADDR_RATE);
  assign wr_mod     = wr_en && (addr == ADDR_MOD);
  assign wr_stat    = wr_en && (addr == ADDR_STAT);
  assign cfg_accept = (wr_rate || wr_mod) && !busy;
  assign set_evt    = evt_req_s ^ evt_seen_q;
  assign clr_evt    = wr_stat && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_en_q    <= 1'b0;
      lp_q        <= '0;
      rate_q      <= '0;
      mod_q       <= '0;
      cfg_req_tog <= 1'b0;
      evt_seen_q  <= 1'b0;
      flag_q      <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        irq_en_q       <= wdata[0];
        lp_q.wait_hold <= wdata[1];
        lp_q.stop_run  <= wdata[2];
        lp_q.dbg_hold  <= wdata[3];
      end
      if (wr_rate && !busy) rate_q <= wdata[RATE_W-1:0];
      if (wr_mod && !busy)  mod_q  <= wdata[MOD_W-1:0];
      if (cfg_accept)       cfg_req_tog <= ~cfg_req_tog;
      evt_seen_q <= evt_req_s;
      flag_q     <= flag_next(flag_q, set_evt, clr_evt);
    end
  end

  assign evt_ack_tog = evt_seen_q;
  assign irq         = flag_q & irq_en_q;

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_CTRL: rdata[3:0]        = {lp_q.dbg_hold, lp_q.stop_run, lp_q.wait_hold, irq_en_q};
      ADDR_RATE: rdata[RATE_W-1:0] = rate_q;
      ADDR_MOD:  rdata[MOD_W-1:0]  = mod_q;
      default:   rdata[1:0]        = {busy, flag_q};
    endcase
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag_q); // R5
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_evt) |=> !flag_q); // R5
  AST_FLAG_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_evt)); // R3
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_accept |=> busy); // R9
  AST_RATE_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_rate) |=> $stable(rate_q)); // R9
  AST_MOD_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_mod) |=> $stable(mod_q)); // R9
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_q |-> !irq); // R4

endmodule

// File: rtl/pit_ref_count.sv
`timescale 1ns/1ps
module pit_ref_count
  import pit_pkg::*;
#(
  parameter int MOD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate_bus,
  input  logic [MOD_W-1:0]  mod_bus,
  input  pit_lp_t           lp_bus,
  input  logic              wait_mode,
  input  logic              stop_mode,
  input  logic              dbg_active,
  input  logic              cfg_req_tog,
  output logic              cfg_ack_tog,
  input  logic              evt_ack_tog,
  output logic              evt_req_tog
);

  localparam int LP_SYNC_W = $bits(pit_lp_t) + 3;

  logic [LP_SYNC_W-1:0] lp_s;
  logic                 cfg_req_s;
  logic                 evt_ack_s;
  logic                 cfg_seen_q;
  logic [RATE_W-1:0]    rate_cur;
  logic [MOD_W-1:0]     mod_cur;
  logic [PRESC_W-1:0]   presc_cnt;
  logic [MOD_W-1:0]     mod_cnt;
  logic                 pend_q;

  // Named internal events
  logic             apply;
  logic             hold;
  logic             run_en;
  logic [DIV_W-1:0] div;
  logic             tick;
  logic             timeout;
  logic             inflight;
  logic             send_evt;

  pit_sync #(.WIDTH(LP_SYNC_W), .STAGES(SYNC_STAGES)) u_lp_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({lp_bus, wait_mode, stop_mode, dbg_active}),
    .q    (lp_s)
  );

  pit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (cfg_req_tog),
    .q    (cfg_req_s)
  );

  pit_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_eack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (evt_ack_tog),
    .q    (evt_ack_s)
  );

  assign apply    = cfg_req_s ^ cfg_seen_q;
  assign hold     = lp_hold(pit_lp_t'(lp_s[LP_SYNC_W-1:3]), lp_s[2], lp_s[1], lp_s[0]);
  assign div      = prescale_div(rate_cur);
  assign run_en   = (|rate_cur) && !hold;
  assign tick     = run_en && ({1'b0, presc_cnt} == (div - DIV_W'(1)));
  assign timeout  = tick && (mod_cnt == '0) && !apply;
  assign inflight = evt_req_tog ^ evt_ack_s;
  assign send_evt = !inflight && (pend_q || timeout);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_seen_q <= 1'b0;
      rate_cur   <= '0;
      mod_cur    <= '0;
      presc_cnt  <= '0;
      mod_cnt    <= '0;
    end else if (apply) begin
      cfg_seen_q <= cfg_req_s;
      rate_cur   <= rate_bus;
      mod_cur    <= mod_bus;
      presc_cnt  <= '0;
      mod_cnt    <= mod_bus;
    end else if (run_en) begin
      presc_cnt <= tick ? '0 : presc_cnt + PRESC_W'(1);
      if (tick) mod_cnt <= (mod_cnt == '0) ? mod_cur : mod_cnt - MOD_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_req_tog <= 1'b0;
      pend_q      <= 1'b0;
    end else if (send_evt) begin
      evt_req_tog <= ~evt_req_tog;
      pend_q      <= 1'b0;
    end else if (timeout) begin
      pend_q <= 1'b1;
    end
  end

  assign cfg_ack_tog = cfg_seen_q;

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_cur == '0) |-> !timeout); // R2
  AST_PRESC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rate_cur) |-> ({1'b0, presc_cnt} < div)); // R1
  AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !apply) |=> ($stable(presc_cnt) && $stable(mod_cnt))); // R6
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    apply |=> (presc_cnt == '0 && mod_cnt == mod_cur)); // R10
  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> (mod_cnt == mod_cur && presc_cnt == '0)); // R3

endmodule

// File: rtl/periodic_irq_timer.sv
`timescale 1ns/1ps
module periodic_irq_timer
  import pit_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int MOD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              bus_clk,
  input  logic              bus_rst_n,
  input  logic              ref_clk,
  input  logic              ref_rst_n,
  input  logic [1:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              wait_mode,
  input  logic              stop_mode,
  input  logic              dbg_active,
  output logic              irq
);

  logic [RATE_W-1:0] rate_q;
  logic [MOD_W-1:0]  mod_q;
  pit_lp_t           lp_q;
  logic              cfg_req_tog;
  logic              cfg_ack_tog;
  logic              evt_req_tog;
  logic              evt_ack_tog;

  pit_bus_regs #(
    .DATA_W     (DATA_W),
    .MOD_W      (MOD_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_regs (
    .clk        (bus_clk),
    .rst_n      (bus_rst_n),
    .addr       (reg_addr),
    .wr_en      (reg_wr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .irq        (irq),
    .rate_q     (rate_q),
    .mod_q      (mod_q),
    .lp_q       (lp_q),
    .cfg_req_tog(cfg_req_tog),
    .cfg_ack_tog(cfg_ack_tog),
    .evt_req_tog(evt_req_tog),
    .evt_ack_tog(evt_ack_tog)
  );

  pit_ref_count #(
    .MOD_W      (MOD_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_count (
    .clk        (ref_clk),
    .rst_n      (ref_rst_n),
    .rate_bus   (rate_q),
    .mod_bus    (mod_q),
    .lp_bus     (lp_q),
    .wait_mode  (wait_mode),
    .stop_mode  (stop_mode),
    .dbg_active (dbg_active),
    .cfg_req_tog(cfg_req_tog),
    .cfg_ack_tog(cfg_ack_tog),
    .evt_ack_tog(evt_ack_tog),
    .evt_req_tog(evt_req_tog)
  );

endmodule

// File: tb/periodic_irq_timer_test.sv
`timescale 1ns/1ps
module periodic_irq_timer_test;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_RATE = 2'd1;
  localparam logic [1:0] A_MOD  = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;
  localparam int REF_NS = 23;
  localparam int N_VEC  = 6;

  // rate code, modulus, expected period in reference cycles
  localparam logic [1:0] T_RATE [N_VEC] = '{2'd1, 2'd1, 2'd2, 2'd2, 2'd3, 2'd1};
  localparam int         T_MOD  [N_VEC] = '{9, 40, 0, 2, 0, 255};
  localparam int         T_PER  [N_VEC] = '{10, 41, 16, 48, 256, 256};

  logic       bus_clk = 1'b0;
  logic       ref_clk = 1'b0;
  logic       bus_rst_n = 1'b0;
  logic       ref_rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       wait_mode = 1'b0;
  logic       stop_mode = 1'b0;
  logic       dbg_active = 1'b0;
  logic       irq;

  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  always #2.5  bus_clk = ~bus_clk;
  always #11.5 ref_clk = ~ref_clk;

  periodic_irq_timer uut (
    .bus_clk   (bus_clk),
    .bus_rst_n (bus_rst_n),
    .ref_clk   (ref_clk),
    .ref_rst_n (ref_rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .wait_mode (wait_mode),
    .stop_mode (stop_mode),
    .dbg_active(dbg_active),
    .irq       (irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge bus_clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge bus_clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge bus_clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_busy();
    logic [7:0] v;
    for (int i = 0; i < 100; i++) begin
      rd(A_STAT, v);
      if (!v[1]) break;
    end
  endtask

  task automatic configure(input logic [1:0] rate, input logic [7:0] m);
    wr(A_RATE, {6'd0, rate}); wait_busy();
    wr(A_MOD, m);             wait_busy();
  endtask

  task automatic wait_irq(input int max_cyc, output bit seen, output realtime t);
    seen = 1'b0; t = 0;
    for (int i = 0; i < max_cyc; i++) begin
      @(negedge bus_clk);
      if (irq) begin seen = 1'b1; t = $realtime; break; end
    end
  endtask

  task automatic lp_case(input logic [7:0] ctrl, input bit w, input bit s, input bit d,
                         input bit expect_run, input string req);
    bit seen; realtime t;
    wr(A_CTRL, ctrl);
    wait_mode = w; stop_mode = s; dbg_active = d;
    #300; wr(A_STAT, 8'h01);
    #300; wr(A_STAT, 8'h01);
    wait_irq(400, seen, t);
    check(seen == expect_run, req, int'(seen), int'(expect_run));
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge bus_clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] v;
    bit s0, s1, s2;
    realtime t0, t1, t2;
    int meas, expv, lim;

    #100;
    bus_rst_n = 1'b1; ref_rst_n = 1'b1;
    #20;

    // R11 reset state
    rd(A_CTRL, v); check(v == 8'h00, "R11 ctrl reset", v, 0);
    rd(A_RATE, v); check(v == 8'h00, "R11 rate reset", v, 0);
    rd(A_MOD,  v); check(v == 8'h00, "R11 mod reset", v, 0);
    rd(A_STAT, v); check(v == 8'h00, "R11 status reset", v, 0);
    check(irq == 1'b0, "R11 irq reset", irq, 0);

    // R2 stopped after reset: no timeout
    #2000; rd(A_STAT, v); check(v[0] == 1'b0, "R2 stopped at reset", v[0], 0);

    // R1 / R3 period table
    wr(A_CTRL, 8'h01);
    for (int k = 0; k < N_VEC; k++) begin
      configure(T_RATE[k], 8'(T_MOD[k]));
      lim = (T_PER[k] * REF_NS * 2) / 5 + 200;
      #400; wr(A_STAT, 8'h01);
      wait_irq(lim, s0, t0); wr(A_STAT, 8'h01);
      wait_irq(lim, s1, t1); wr(A_STAT, 8'h01);
      wait_irq(lim, s2, t2);
      check(s0 && s1 && s2, "R3 periodic flag", int'(s0) + int'(s1) + int'(s2), 3);
      meas = $rtoi(t2 - t1);
      expv = T_PER[k] * REF_NS;
      check((meas - expv <= 25) && (expv - meas <= 25), "R1 period ns", meas, expv);
    end

    // R2 rate 00 stops the count
    configure(2'd0, 8'd5);
    #400; wr(A_STAT, 8'h01);
    #3000; rd(A_STAT, v);
    check(v[0] == 1'b0, "R2 rate zero quiet", v[0], 0);
    check(irq == 1'b0, "R2 irq quiet", irq, 0);

    // R9 busy and ignored writes
    wr(A_RATE, 8'h02);
    rd(A_STAT, v); check(v[1] == 1'b1, "R9 busy after write", v[1], 1);
    wr(A_RATE, 8'h03);
    wait_busy();
    rd(A_RATE, v); check(v == 8'h02, "R9 rate write ignored", v, 2);
    wr(A_MOD, 8'd50);
    wr(A_MOD, 8'd7);
    wait_busy();
    rd(A_MOD, v);  check(v == 8'd50, "R9 mod write ignored", v, 50);
    rd(A_STAT, v); check(v[1] == 1'b0, "R9 busy clears", v[1], 0);

    // R4 / R5 masking and write-one-to-clear
    wr(A_CTRL, 8'h00);
    configure(2'd1, 8'd200);
    #400; wr(A_STAT, 8'h01);
    #5000;
    rd(A_STAT, v); check(v[0] == 1'b1, "R3 flag set", v[0], 1);
    check(irq == 1'b0, "R4 masked irq", irq, 0);
    wr(A_CTRL, 8'h01);
    @(negedge bus_clk); check(irq == 1'b1, "R4 irq enabled", irq, 1);
    wr(A_STAT, 8'h00);
    rd(A_STAT, v); check(v[0] == 1'b1, "R5 write zero keeps flag", v[0], 1);
    wr(A_STAT, 8'h01);
    rd(A_STAT, v); check(v[0] == 1'b0, "R5 write one clears", v[0], 0);
    check(irq == 1'b0, "R4 irq follows flag", irq, 0);

    // R10 restart after a modulus update mid-period
    wait_irq(2200, s0, t0);
    #2300;
    wr(A_MOD, 8'd9);
    wait_busy();
    wr(A_STAT, 8'h01);
    t1 = $realtime;
    wait_irq(200, s1, t2);
    meas = $rtoi(t2 - t1);
    check(s1 && (meas <= 10 * REF_NS + 60), "R10 restart period", meas, 10 * REF_NS);

    // R6 / R7 / R8 low-power and debug holds (period is 10 cycles now)
    lp_case(8'h03, 1'b1, 1'b0, 1'b0, 1'b0, "R6 wait hold");
    lp_case(8'h01, 1'b1, 1'b0, 1'b0, 1'b1, "R6 wait runs");
    lp_case(8'h03, 1'b0, 1'b0, 1'b0, 1'b1, "R6 no wait runs");
    lp_case(8'h01, 1'b0, 1'b1, 1'b0, 1'b0, "R7 stop hold");
    lp_case(8'h05, 1'b0, 1'b1, 1'b0, 1'b1, "R7 stop runs");
    lp_case(8'h09, 1'b0, 1'b0, 1'b1, 1'b0, "R8 debug hold");
    lp_case(8'h01, 1'b0, 1'b0, 1'b1, 1'b1, "R8 debug ignored");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule